// File: doc/BRIEF.md
# Sector protection lock controller

This block keeps the write-protection state of a serial flash style memory. It holds one protection flag per sector and a lock flag that lives in the status register. Software changes the flags through decoded single-cycle command pulses: protect one sector, unprotect one sector, or write the status byte. Command decoding and write-enable handling happen upstream, and the memory array is separate.

The active-low write-protect pin never gates the array directly. The pin passes through a two-flop synchroniser and is then combined with the lock flag to pick one of three modes:

- **Unlocked:** the lock flag is 0.
- **Software locked:** the lock flag is 1 and the synchronised pin is high.
- **Hardware locked:** the lock flag is 1 and the synchronised pin is low.

A status write can also protect or unprotect every sector at once, but only while the sector flags are unlocked. That covers the write that sets the lock flag, and never the write that clears it. The block drops every command the current mode forbids and reports it with a one-cycle pulse.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After synchronous reset every sector flag is 1 (protected), `lock_bit` is 0 and `cmd_ignored` is 0; with the pin held low this is the only way back from a lock flag of 1.
- R2: `wp_n` reaches the mode logic through two flops. A change applied before clock edge k first affects a command processed at edge k+2. Hardware lock applies when the synchronised pin is 0 and `lock_bit` is 1.
- R3: With `lock_bit` at 0, a protect pulse sets and an unprotect pulse clears the flag selected by `sector_addr`, visible after the processing edge.
- R4: With `lock_bit` at 0, a status write loads `lock_bit` from `status_data[7]`.
- R5: With `lock_bit` at 0, a status write with `status_data[5:2]` = 4'b1111 sets all sector flags and 4'b0000 clears them all, in the same edge that loads `lock_bit`; any other code leaves the sectors alone.
- R6: Software locked: protect and unprotect pulses are dropped and no sector flag changes.
- R7: Software locked: a status write loads `lock_bit` from `status_data[7]` (so it may clear it), and its global field is not applied.
- R8: Hardware locked: protect, unprotect and status write are all dropped; sector flags and `lock_bit` keep their values.
- R9: `cmd_ignored` is 1 for exactly the cycle after each edge that dropped a command, and 0 after edges with no command or an accepted one.
- R10: If several pulses coincide, only one is taken, in the order status write, then protect, then unprotect; the others vanish without raising `cmd_ignored`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| wp_n | input | 1 | Asynchronous active-low write-protect pin |
| cmd_protect | input | 1 | Protect-sector pulse |
| cmd_unprotect | input | 1 | Unprotect-sector pulse |
| cmd_wr_status | input | 1 | Status-write pulse |
| sector_addr | input | SECT_AW | Sector selected by protect/unprotect |
| status_data | input | 8 | Status byte: bit 7 lock flag, bits 5:2 global code |
| sector_prot | output | NUM_SECTORS | Per-sector protection flags, 1 = protected |
| lock_bit | output | 1 | Lock flag |
| cmd_ignored | output | 1 | One-cycle pulse after a dropped command |

## Verification
The assertions watch every cycle for several properties:

- Hardware lock freezes both the sector flags and the lock flag.
- Software lock and status writes under software lock leave the sector flags untouched.
- An unlocked status write lands `status_data[7]` in the lock flag, and a global code reaches every sector.
- An ignore pulse always follows a command.
- The synchroniser output trails the pin by two edges.

Other properties depend on ordered stimulus, so only the bench scenarios show them:

- The two-edge window in which a pin release still leaves a command hardware locked.
- Clearing the lock while the global field is silently dropped.
- The exact arbitration among simultaneous pulses.
- A lock flag of 1 surviving everything except reset while the pin is low.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [1:0] {
    MODE_OPEN = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_HARD = 2'd2
  } lock_mode_t;

  localparam int STATUS_W     = 8;
  localparam int LOCK_POS     = 7;
  localparam int GLOB_HI      = 5;
  localparam int GLOB_LO      = 2;
  localparam int GLOB_W       = GLOB_HI - GLOB_LO + 1;
  localparam logic [GLOB_W-1:0] GLOB_SET_ALL = '1;
  localparam logic [GLOB_W-1:0] GLOB_CLR_ALL = '0;

endpackage

// File: rtl/slc_pin_sync.sv
module slc_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], pin_in};
  end

  assign pin_sync = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (pin_sync == $past(pin_in, 2))) // R2
        else $error("sync delay");
    end
  endgenerate

endmodule

// File: rtl/slc_mode_decode.sv
module slc_mode_decode
  import slc_pkg::*;
(
  input  logic       lock_q,
  input  logic       wp_sync,
  input  logic       req_prot,
  input  logic       req_unprot,
  input  logic       req_wrsr,
  output lock_mode_t mode,
  output logic       set_en,
  output logic       clr_en,
  output logic       glob_en,
  output logic       lock_we,
  output logic       drop_now
);

  logic sel_wrsr, sel_prot, sel_unprot;

  always_comb begin
    // arbitration: status write, then protect, then unprotect
    sel_wrsr   = req_wrsr;
    sel_prot   = req_prot & ~req_wrsr;
    sel_unprot = req_unprot & ~req_wrsr & ~req_prot;

    if (!lock_q)      mode = MODE_OPEN;
    else if (!wp_sync) mode = MODE_HARD;
    else              mode = MODE_SOFT;

    set_en   = 1'b0;
    clr_en   = 1'b0;
    glob_en  = 1'b0;
    lock_we  = 1'b0;
    drop_now = 1'b0;

    unique case (mode)
      MODE_OPEN: begin
        set_en  = sel_prot;
        clr_en  = sel_unprot;
        glob_en = sel_wrsr;
        lock_we = sel_wrsr;
      end
      MODE_SOFT: begin
        lock_we  = sel_wrsr;
        drop_now = sel_prot | sel_unprot;
      end
      MODE_HARD: begin
        drop_now = sel_wrsr | sel_prot | sel_unprot;
      end
      default: begin
        drop_now = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/slc_sector_bank.sv
module slc_sector_bank
  import slc_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_AW     = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic [SECT_AW-1:0]     idx,
  input  logic                   glob_en,
  input  logic [GLOB_W-1:0]      glob_code,
  output logic [NUM_SECTORS-1:0] prot_q
);

  logic glob_set, glob_clr;

  assign glob_set = glob_en && (glob_code == GLOB_SET_ALL);
  assign glob_clr = glob_en && (glob_code == GLOB_CLR_ALL);

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sect
    logic hit;
    assign hit = (idx == SECT_AW'(i));

    always_ff @(posedge clk) begin
      if (rst)                prot_q[i] <= 1'b1;
      else if (glob_set)      prot_q[i] <= 1'b1;
      else if (glob_clr)      prot_q[i] <= 1'b0;
      else if (set_en && hit) prot_q[i] <= 1'b1;
      else if (clr_en && hit) prot_q[i] <= 1'b0;
    end
  end

  AST_GLOBAL_SET: assert property (@(posedge clk) disable iff (rst)
    (glob_en && glob_code == GLOB_SET_ALL) |=> (&prot_q)) // R5
    else $error("global set");

  AST_GLOBAL_CLR: assert property (@(posedge clk) disable iff (rst)
    (glob_en && glob_code == GLOB_CLR_ALL) |=> (prot_q == '0)) // R5
    else $error("global clear");

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en && !glob_en) |=> $stable(prot_q)) // R6
    else $error("bank moved while idle");

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
  import slc_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int SECT_AW     = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wp_n,
  input  logic                   cmd_protect,
  input  logic                   cmd_unprotect,
  input  logic                   cmd_wr_status,
  input  logic [SECT_AW-1:0]     sector_addr,
  input  logic [STATUS_W-1:0]    status_data,
  output logic [NUM_SECTORS-1:0] sector_prot,
  output logic                   lock_bit,
  output logic                   cmd_ignored
);

  logic       wp_sync;
  lock_mode_t mode;
  logic       set_en, clr_en, glob_en, lock_we, drop_now;
  logic       lock_q, ign_q;
  logic       any_cmd;
  logic       unused_status;

  assign unused_status = ^{status_data[6], status_data[1:0]};
  assign any_cmd = cmd_protect | cmd_unprotect | cmd_wr_status;

  slc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (wp_n),
    .pin_sync (wp_sync)
  );

  slc_mode_decode u_mode (
    .lock_q     (lock_q),
    .wp_sync    (wp_sync),
    .req_prot   (cmd_protect),
    .req_unprot (cmd_unprotect),
    .req_wrsr   (cmd_wr_status),
    .mode       (mode),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .glob_en    (glob_en),
    .lock_we    (lock_we),
    .drop_now   (drop_now)
  );

  slc_sector_bank #(.NUM_SECTORS(NUM_SECTORS), .SECT_AW(SECT_AW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_en    (set_en),
    .clr_en    (clr_en),
    .idx       (sector_addr),
    .glob_en   (glob_en),
    .glob_code (status_data[GLOB_HI:GLOB_LO]),
    .prot_q    (sector_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      ign_q  <= 1'b0;
    end else begin
      if (lock_we) lock_q <= status_data[LOCK_POS];
      ign_q <= drop_now;
    end
  end

  assign lock_bit    = lock_q;
  assign cmd_ignored = ign_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (&sector_prot && !lock_bit && !cmd_ignored)) // R1
    else $error("reset state");

  AST_HARD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HARD && any_cmd) |=> ($stable(sector_prot) && $stable(lock_bit))) // R8
    else $error("hard lock leak");

  AST_SOFT_SECTORS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SOFT && any_cmd) |=> $stable(sector_prot)) // R7
    else $error("soft lock leak");

  AST_OPEN_LOCK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!lock_bit && cmd_wr_status) |=> (lock_bit == $past(status_data[LOCK_POS]))) // R4
    else $error("lock load");

  AST_HARD_NEEDS_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HARD) |-> (lock_bit && !wp_sync)) // R2
    else $error("mode decode");

  AST_IGNORE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cmd_ignored |-> $past(any_cmd)) // R9
    else $error("spurious ignore");

endmodule

// File: tb/sim_sector_lock_ctrl.sv
module sim_sector_lock_ctrl;
  localparam int  NS      = 64;
  localparam int  AW      = 6;
  localparam time CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_n = 1'b1;
  logic          c_prot = 1'b0, c_unprot = 1'b0, c_wrsr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [NS-1:0] prot;
  logic          lock, ign;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [NS-1:0] m_prot;
  logic          m_lock, m_ign, m_s1, m_s2;

  always #(CLK_PER/2) clk = ~clk;

  sector_lock_ctrl #(.NUM_SECTORS(NS), .SECT_AW(AW)) u0 (
    .clk(clk), .rst(rst), .wp_n(wp_n),
    .cmd_protect(c_prot), .cmd_unprotect(c_unprot), .cmd_wr_status(c_wrsr),
    .sector_addr(addr), .status_data(data),
    .sector_prot(prot), .lock_bit(lock), .cmd_ignored(ign)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_prot <= '1; m_lock <= 1'b0; m_ign <= 1'b0; m_s1 <= 1'b1; m_s2 <= 1'b1;
    end else begin
      m_s1 <= wp_n;
      m_s2 <= m_s1;
      m_ign <= 1'b0;
      if (m_lock && !m_s2) begin
        if (c_wrsr || c_prot || c_unprot) m_ign <= 1'b1;
      end else if (c_wrsr) begin
        m_lock <= data[7];
        if (!m_lock) begin
          if (data[5:2] == 4'hF) m_prot <= '1;
          else if (data[5:2] == 4'h0) m_prot <= '0;
        end
      end else if (c_prot || c_unprot) begin
        if (m_lock) m_ign <= 1'b1;
        else m_prot[addr] <= c_prot;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(prot == m_prot, cur_req, "model prot", prot, m_prot);
      check(lock == m_lock, cur_req, "model lock", {63'd0, lock}, {63'd0, m_lock});
      check(ign == m_ign, cur_req, "model ignored", {63'd0, ign}, {63'd0, m_ign});
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // kinds: 1 protect, 2 unprotect, 4 status write (may be ORed)
  task automatic issue(input int kind, input int a, input logic [7:0] d);
    @(negedge clk);
    c_prot = kind[0]; c_unprot = kind[1]; c_wrsr = kind[2];
    addr = AW'(a); data = d;
    @(negedge clk);
    c_prot = 1'b0; c_unprot = 1'b0; c_wrsr = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    wp_n = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check(prot == '1 && !lock && !ign, "R1", "reset state", {prot[62:0], lock}, {63'h7FFF_FFFF_FFFF_FFFF, 1'b0});

    cur_req = "R3";
    issue(2, 5, 8'h00);
    check(prot[5] == 1'b0 && ign == 1'b0, "R3", "unprotect 5", {63'd0, prot[5]}, 64'd0);
    issue(1, 5, 8'h00);
    check(prot[5] == 1'b1, "R3", "protect 5", {63'd0, prot[5]}, 64'd1);
    issue(2, 0, 8'h00);
    issue(2, 63, 8'h00);
    check(prot[0] == 1'b0 && prot[63] == 1'b0 && prot[62:1] == '1, "R3", "edge sectors", prot, {1'b0, 62'h3FFF_FFFF_FFFF_FFFF, 1'b0});

    cur_req = "R5";
    issue(4, 0, 8'h00);
    check(prot == '0 && !lock, "R5", "global clear", prot, 64'd0);
    issue(4, 0, 8'h3C);
    check(prot == '1, "R5", "global set", prot, '1);
    issue(2, 7, 8'h00);
    issue(4, 0, 8'h14);
    check(prot[7] == 1'b0 && prot[6] == 1'b1, "R5", "other code keeps sectors", prot, {56'hFF_FFFF_FFFF_FFFF, 8'h7F});

    cur_req = "R4";
    issue(4, 0, 8'h80);
    check(lock && prot == '0, "R4", "lock set with global clear", {63'd0, lock}, 64'd1);

    cur_req = "R6";
    issue(1, 3, 8'h00);
    check(prot == '0 && ign, "R6", "soft protect dropped", prot, 64'd0);
    @(negedge clk);
    check(!ign, "R9", "pulse lasts one cycle", {63'd0, ign}, 64'd0);

    cur_req = "R7";
    issue(4, 0, 8'h3C);
    check(!lock && prot == '0 && !ign, "R7", "soft clear without global", prot, 64'd0);

    cur_req = "R8";
    issue(4, 0, 8'hBC);
    check(lock && prot == '1, "R5", "global set with lock", prot, '1);
    set_pin(1'b0);
    issue(2, 2, 8'h00);
    check(prot[2] && ign, "R8", "hard unprotect dropped", {63'd0, prot[2]}, 64'd1);
    issue(4, 0, 8'h00);
    check(lock && prot == '1 && ign, "R8", "hard status write dropped", {63'd0, lock}, 64'd1);
    repeat (5) @(negedge clk);
    check(lock == 1'b1, "R1", "lock persists while pin low", {63'd0, lock}, 64'd1);

    cur_req = "R2";
    @(negedge clk);
    wp_n = 1'b1;
    issue(4, 0, 8'h00);
    check(lock && ign, "R2", "still hard inside sync window", {63'd0, lock}, 64'd1);
    issue(4, 0, 8'h00);
    check(!lock && !ign, "R2", "soft after sync window", {63'd0, lock}, 64'd0);

    cur_req = "R10";
    issue(4, 0, 8'h00);
    issue(3, 9, 8'h00);
    check(prot[9] && !ign, "R10", "protect beats unprotect", {63'd0, prot[9]}, 64'd1);
    issue(5, 11, 8'h00);
    check(prot == '0, "R10", "status write beats protect", prot, 64'd0);

    cur_req = "R1";
    set_pin(1'b0);
    issue(4, 0, 8'h80);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(prot == '1 && !lock, "R1", "reset clears lock with pin low", {63'd0, lock}, 64'd0);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule